// File: doc/BRIEF.md
# Flash Quick-Pulse Program and Erase Sequencer

This block drives an external flash device that is programmed with a 12 V supply. It writes single bytes and erases the whole chip by pulse-and-verify. Each attempt is a timed programming (or erase) strobe, followed by a recovery wait and a read-back compare. The number of attempts has a bound. Every interval is computed from the clock frequency parameter, so the same code serves any clock.

A request carries an address and a data byte. It is refused at once if the programming supply is not reported good or if the write-lock input is high. Otherwise the sequencer first reads the device identifier and refuses devices it does not recognise. A chip erase first programs every byte to 00h and only then starts erase pulses. It then checks that every byte reads FFh. When the operation ends, a one-cycle done pulse appears and a status code describes the result.

Top module: `qpulse_seq`

## Requirements
- R1: A request while idle with `vpp_ok` low produces no strobe and leaves `busy` low. It gives `done` in the next cycle with status NO_VPP (2). This check wins over the write-lock check.
- R2: A request while idle with `vpp_ok` high and `wp_in` high produces no strobe and leaves `busy` low. It gives `done` in the next cycle with status PROTECTED (3).
- R3: An accepted request reads the identifier with `fl_id` and `fl_rd` high: the manufacturer code at `fl_addr` 0, then the device code at `fl_addr` 1. Manufacturer 89h with device B4h or BDh proceeds. Any other code ends with status BAD_ID (4) and no strobe.
- R4: Each program strobe keeps `fl_prog` high for exactly CLK_HZ*PROG_PULSE_NS/1e9 consecutive cycles (500 at 50 MHz for 10 µs).
- R5: After every strobe, at least CLK_HZ*RECOVER_NS/1e9 cycles (300 for 6 µs) pass before the verify read. A program verify compares `fl_rdata` with the request data.
- R6: A byte program makes at most PROG_TRIES (25) attempts. It ends OK (0) on the first matching verify, or VERIFY_FAIL (1) if the attempt that reaches the limit still fails.
- R7: A chip erase programs every address from 0 to the top to 00h, each with the R6 loop, before the first `fl_erase` strobe.
- R8: Erase strobes last CLK_HZ*ERASE_PULSE_NS/1e9 cycles. After each strobe and recovery, bytes are verified for FFh upward from the last failing address. The result is OK when the top address passes, or VERIFY_FAIL after ERASE_TRIES strobes.
- R9: `busy` is high from the cycle after an accepted request until the done cycle. `done` is high for one cycle, and `status` holds its code until the next `done`.
- R10: A request while `busy` is high is ignored. When both request inputs are high, the program request wins.
- R11: A synchronous `rst` returns the block to idle: `busy`, `done`, `fl_prog` and `fl_erase` are low and `status` is OK.
- R12: `fl_prog` and `fl_erase` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_prog | input | 1 | Byte program request strobe |
| req_erase | input | 1 | Chip erase request strobe |
| req_addr | input | ADDR_W | Byte address for a program |
| req_data | input | 8 | Data byte for a program |
| vpp_ok | input | 1 | Programming supply is valid |
| wp_in | input | 1 | Write lock, high refuses requests |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 3 | Result: 0 OK, 1 VERIFY_FAIL, 2 NO_VPP, 3 PROTECTED, 4 BAD_ID |
| fl_addr | output | ADDR_W | Flash address |
| fl_wdata | output | 8 | Flash write data |
| fl_id | output | 1 | Identifier read mode |
| fl_rd | output | 1 | Read strobe, data sampled the same cycle |
| fl_prog | output | 1 | Program pulse |
| fl_erase | output | 1 | Erase pulse |
| fl_rdata | input | 8 | Flash read data |

## Verification
Several properties are checked on every cycle. These are the exact program strobe width, the minimum recovery gap before a verify read, the exclusion between the two strobes, the one-cycle shape of `done`, the quiet state after reset, and the immediate refusals for a bad supply or write lock. Other behaviour is visible only in the bench scenarios, which run against a flash model whose cells need a chosen number of pulses. These scenarios cover the attempt count at and just past the limit, the identifier decisions, the 00h preprogramming before any erase strobe, erase retry exhaustion, request priority, and requests dropped while busy.

// File: rtl/qpulse_seq.sv
module qpulse_seq #(
  parameter int CLK_HZ         = 50_000_000,
  parameter int PROG_PULSE_NS  = 10_000,
  parameter int RECOVER_NS     = 6_000,
  parameter int ERASE_PULSE_NS = 10_000_000,
  parameter int PROG_TRIES     = 25,
  parameter int ERASE_TRIES    = 1000,
  parameter int ADDR_W         = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_prog,
  input  logic              req_erase,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_data,
  input  logic              vpp_ok,
  input  logic              wp_in,
  output logic              busy,
  output logic              done,
  output logic [2:0]        status,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [7:0]        fl_wdata,
  output logic              fl_id,
  output logic              fl_rd,
  output logic              fl_prog,
  output logic              fl_erase,
  input  logic [7:0]        fl_rdata
);
  localparam longint PCYC = (longint'(CLK_HZ) * PROG_PULSE_NS) / 1_000_000_000;
  localparam longint RCYC = (longint'(CLK_HZ) * RECOVER_NS) / 1_000_000_000;
  localparam longint ECYC = (longint'(CLK_HZ) * ERASE_PULSE_NS) / 1_000_000_000;
  localparam longint TMAX = (PCYC > ECYC ? PCYC : ECYC) > RCYC ? (PCYC > ECYC ? PCYC : ECYC) : RCYC;
  localparam int     TW   = $clog2(TMAX + 1);
  localparam int     NMAX = PROG_TRIES > ERASE_TRIES ? PROG_TRIES : ERASE_TRIES;
  localparam int     CW   = $clog2(NMAX + 1);

  localparam logic [2:0] R_OK = 3'd0, R_VFAIL = 3'd1, R_NOVPP = 3'd2, R_LOCK = 3'd3, R_BADID = 3'd4;

  typedef enum logic [3:0] {
    S_IDLE, S_IDM, S_IDD, S_PP, S_PR, S_PV, S_EP, S_ER, S_EV
  } state_t;

  state_t            state;
  logic [TW-1:0]     tmr;
  logic [CW-1:0]     tries;
  logic [ADDR_W-1:0] addr;
  logic [7:0]        data;
  logic              erase_op;
  logic              done_q;
  logic [2:0]        stat_q;

  wire tmr_zero = (tmr == '0);
  wire at_top   = &addr;

  assign busy     = (state != S_IDLE);
  assign done     = done_q;
  assign status   = stat_q;
  assign fl_id    = (state == S_IDM) || (state == S_IDD);
  assign fl_rd    = fl_id || (state == S_PV) || (state == S_EV);
  assign fl_prog  = (state == S_PP);
  assign fl_erase = (state == S_EP);
  assign fl_wdata = data;
  assign fl_addr  = (state == S_IDD) ? ADDR_W'(1) : (state == S_IDM) ? '0 : addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      tmr      <= '0;
      tries    <= '0;
      addr     <= '0;
      data     <= '0;
      erase_op <= 1'b0;
      done_q   <= 1'b0;
      stat_q   <= R_OK;
    end else begin
      done_q <= 1'b0;
      case (state)
        S_IDLE: if (req_prog || req_erase) begin
          erase_op <= !req_prog;
          addr     <= req_prog ? req_addr : '0;
          data     <= req_prog ? req_data : 8'h00;
          if (!vpp_ok) begin
            done_q <= 1'b1;
            stat_q <= R_NOVPP;
          end else if (wp_in) begin
            done_q <= 1'b1;
            stat_q <= R_LOCK;
          end else begin
            state <= S_IDM;
          end
        end
        S_IDM: if (fl_rdata == 8'h89) state <= S_IDD;
        else begin
          state  <= S_IDLE;
          done_q <= 1'b1;
          stat_q <= R_BADID;
        end
        S_IDD: if (fl_rdata == 8'hB4 || fl_rdata == 8'hBD) begin
          state <= S_PP;
          tmr   <= TW'(PCYC - 1);
          tries <= '0;
        end else begin
          state  <= S_IDLE;
          done_q <= 1'b1;
          stat_q <= R_BADID;
        end
        S_PP: if (tmr_zero) begin
          state <= S_PR;
          tmr   <= TW'(RCYC - 1);
          tries <= tries + 1'b1;
        end else tmr <= tmr - 1'b1;
        S_PR: if (tmr_zero) state <= S_PV;
        else tmr <= tmr - 1'b1;
        S_PV: if (fl_rdata == data) begin
          if (!erase_op) begin
            state  <= S_IDLE;
            done_q <= 1'b1;
            stat_q <= R_OK;
          end else if (at_top) begin
            state <= S_EP;
            tmr   <= TW'(ECYC - 1);
            tries <= '0;
            addr  <= '0;
          end else begin
            addr  <= addr + 1'b1;
            tries <= '0;
            state <= S_PP;
            tmr   <= TW'(PCYC - 1);
          end
        end else if (tries == CW'(PROG_TRIES)) begin
          state  <= S_IDLE;
          done_q <= 1'b1;
          stat_q <= R_VFAIL;
        end else begin
          state <= S_PP;
          tmr   <= TW'(PCYC - 1);
        end
        S_EP: if (tmr_zero) begin
          state <= S_ER;
          tmr   <= TW'(RCYC - 1);
          tries <= tries + 1'b1;
        end else tmr <= tmr - 1'b1;
        S_ER: if (tmr_zero) state <= S_EV;
        else tmr <= tmr - 1'b1;
        S_EV: if (fl_rdata == 8'hFF) begin
          if (at_top) begin
            state  <= S_IDLE;
            done_q <= 1'b1;
            stat_q <= R_OK;
          end else addr <= addr + 1'b1;
        end else if (tries == CW'(ERASE_TRIES)) begin
          state  <= S_IDLE;
          done_q <= 1'b1;
          stat_q <= R_VFAIL;
        end else begin
          state <= S_EP;
          tmr   <= TW'(ECYC - 1);
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/qpulse_seq_chk.sv
module qpulse_seq_chk #(
  parameter int CLK_HZ        = 50_000_000,
  parameter int PROG_PULSE_NS = 10_000,
  parameter int RECOVER_NS    = 6_000
) (
  input logic       clk,
  input logic       rst,
  input logic       req_prog,
  input logic       req_erase,
  input logic       vpp_ok,
  input logic       wp_in,
  input logic       busy,
  input logic       done,
  input logic [2:0] status,
  input logic       fl_id,
  input logic       fl_rd,
  input logic       fl_prog,
  input logic       fl_erase
);
  localparam int WIDE = int'((longint'(CLK_HZ) * PROG_PULSE_NS) / 1_000_000_000);
  localparam int GAP  = int'((longint'(CLK_HZ) * RECOVER_NS) / 1_000_000_000);

  int  run;
  int  gap;
  logic rst_q;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) run <= 0;
    else run <= fl_prog ? run + 1 : 0;
    if (fl_prog || fl_erase) gap <= 0;
    else if (gap < 32'h3fff_ffff) gap <= gap + 1;
  end

  wire req_any = req_prog || req_erase;

  a_r1_novpp_reject: assert property (@(posedge clk) disable iff (rst)
    (!busy && req_any && !vpp_ok) |=> (done && status == 3'd2 && !busy && !fl_prog && !fl_erase));
  a_r2_lock_reject: assert property (@(posedge clk) disable iff (rst)
    (!busy && req_any && vpp_ok && wp_in) |=> (done && status == 3'd3 && !busy && !fl_prog && !fl_erase));
  a_r4_pulse_width: assert property (@(posedge clk) disable iff (rst)
    ($fell(fl_prog) && !rst_q) |-> (run == WIDE));
  a_r5_recovery_gap: assert property (@(posedge clk) disable iff (rst)
    ($rose(fl_rd) && !fl_id && !rst_q) |-> (gap >= GAP));
  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r11_reset_idle: assert property (@(posedge clk)
    rst |=> (!busy && !done && !fl_prog && !fl_erase && status == 3'd0));
  a_r12_strobe_excl: assert property (@(posedge clk) disable iff (rst)
    !(fl_prog && fl_erase));
endmodule

bind qpulse_seq qpulse_seq_chk #(
  .CLK_HZ(CLK_HZ), .PROG_PULSE_NS(PROG_PULSE_NS), .RECOVER_NS(RECOVER_NS)
) u_chk (
  .clk(clk), .rst(rst), .req_prog(req_prog), .req_erase(req_erase),
  .vpp_ok(vpp_ok), .wp_in(wp_in), .busy(busy), .done(done), .status(status),
  .fl_id(fl_id), .fl_rd(fl_rd), .fl_prog(fl_prog), .fl_erase(fl_erase)
);

// File: tb/sim_qpulse_seq.sv
module sim_qpulse_seq;
  localparam int AW = 3;
  localparam int N  = 1 << AW;

  logic clk = 0;
  logic rst = 1;
  logic req_prog = 0, req_erase = 0, vpp_ok = 1, wp_in = 0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0] req_data = '0;
  logic busy, done, fl_id, fl_rd, fl_prog, fl_erase;
  logic [2:0] status;
  logic [AW-1:0] fl_addr;
  logic [7:0] fl_wdata, fl_rdata;

  always #10 clk = ~clk;

  qpulse_seq #(.ERASE_PULSE_NS(20_000), .ERASE_TRIES(4), .ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .req_prog(req_prog), .req_erase(req_erase),
    .req_addr(req_addr), .req_data(req_data), .vpp_ok(vpp_ok), .wp_in(wp_in),
    .busy(busy), .done(done), .status(status), .fl_addr(fl_addr),
    .fl_wdata(fl_wdata), .fl_id(fl_id), .fl_rd(fl_rd), .fl_prog(fl_prog),
    .fl_erase(fl_erase), .fl_rdata(fl_rdata)
  );

  // flash model
  logic stub_init = 0;
  logic [7:0] init_val = 8'hFF, man_code = 8'h89, dev_code = 8'hB4;
  int base_need = 1, hard_need = 1, erase_need = 1;
  logic [AW-1:0] hard_addr = '0;
  logic [7:0] mem [N];
  int pcnt [N];
  int prog_pulses, erase_pulses, ecnt, last_width, wcnt, gap, min_gap;
  logic prog_q, erase_q, rd_q, pre_ok, all_zero;
  int done_cnt = 0;
  logic busy_seen = 0;

  assign fl_rdata = fl_id ? (fl_addr[0] ? dev_code : man_code) : mem[fl_addr];

  always_comb begin
    all_zero = 1'b1;
    for (int i = 0; i < N; i++) if (mem[i] != 8'h00) all_zero = 1'b0;
  end

  always @(posedge clk) begin
    if (stub_init) begin
      for (int i = 0; i < N; i++) begin
        mem[i]  <= init_val;
        pcnt[i] <= 0;
      end
      prog_pulses <= 0; erase_pulses <= 0; ecnt <= 0; pre_ok <= 0;
      min_gap <= 1_000_000; last_width <= 0;
    end else begin
      if (fl_prog && !prog_q) prog_pulses <= prog_pulses + 1;
      if (!fl_prog && prog_q) begin
        last_width <= wcnt;
        pcnt[fl_addr] <= pcnt[fl_addr] + 1;
        if (pcnt[fl_addr] + 1 >= ((fl_addr == hard_addr) ? hard_need : base_need))
          mem[fl_addr] <= fl_wdata;
      end
      if (fl_erase && !erase_q) begin
        erase_pulses <= erase_pulses + 1;
        if (erase_pulses == 0) pre_ok <= all_zero;
      end
      if (!fl_erase && erase_q) begin
        ecnt <= ecnt + 1;
        if (ecnt + 1 >= erase_need) for (int i = 0; i < N; i++) mem[i] <= 8'hFF;
      end
      if (fl_rd && !rd_q && !fl_id && gap < min_gap) min_gap <= gap;
    end
    prog_q  <= fl_prog;
    erase_q <= fl_erase;
    rd_q    <= fl_rd;
    wcnt    <= fl_prog ? wcnt + 1 : 0;
    gap     <= (fl_prog || fl_erase) ? 0 : gap + 1;
    if (done) done_cnt <= done_cnt + 1;
    if (busy) busy_seen <= 1'b1;
  end

  int n_chk = 0, n_fail = 0;

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic setup(input logic [7:0] iv, input int bn, input logic [AW-1:0] ha, input int hn, input int en);
    @(negedge clk);
    init_val = iv; base_need = bn; hard_addr = ha; hard_need = hn; erase_need = en;
    stub_init = 1; busy_seen = 0;
    @(negedge clk);
    stub_init = 0;
  endtask

  task automatic request(input logic p, input logic e, input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    req_prog = p; req_erase = e; req_addr = a; req_data = d;
    @(negedge clk);
    req_prog = 0; req_erase = 0;
  endtask

  task automatic wait_done(input int start, input string tag);
    int i;
    for (i = 0; i < 60000 && done_cnt == start; i++) @(negedge clk);
    check(done_cnt != start, {tag, " done timeout"}, done_cnt, start + 1);
  endtask

  task automatic t_reset;
    check(!busy && !done, "R11 idle after reset", {busy, done}, 0);
    check(!fl_prog && !fl_erase, "R11 strobes low", {fl_prog, fl_erase}, 0);
    check(status == 3'd0, "R11 status OK", status, 0);
  endtask

  task automatic t_novpp;
    setup(8'hFF, 1, '0, 1, 1);
    vpp_ok = 0; wp_in = 1;
    request(1, 0, 3'd2, 8'h12);
    check(done && status == 3'd2, "R1 NO_VPP next cycle", {done, status}, 4'hA);
    @(negedge clk);
    check(!done, "R9 done one cycle", done, 0);
    check(!busy_seen && prog_pulses == 0, "R1 no busy no pulse", prog_pulses, 0);
    vpp_ok = 1; wp_in = 0;
  endtask

  task automatic t_lock;
    setup(8'hFF, 1, '0, 1, 1);
    wp_in = 1;
    request(0, 1, 3'd0, 8'h00);
    check(done && status == 3'd3, "R2 PROTECTED next cycle", {done, status}, 4'hB);
    repeat (3) @(negedge clk);
    check(!busy_seen && prog_pulses == 0 && erase_pulses == 0, "R2 no pulse", prog_pulses + erase_pulses, 0);
    wp_in = 0;
  endtask

  task automatic t_badid;
    int s;
    setup(8'hFF, 1, '0, 1, 1);
    man_code = 8'h88; s = done_cnt;
    request(1, 0, 3'd1, 8'h55);
    wait_done(s, "R3");
    check(status == 3'd4 && prog_pulses == 0, "R3 bad manufacturer", status, 4);
    man_code = 8'h89; dev_code = 8'hB5; s = done_cnt;
    request(1, 0, 3'd1, 8'h55);
    wait_done(s, "R3");
    check(status == 3'd4 && prog_pulses == 0, "R3 bad device", status, 4);
    dev_code = 8'hBD; s = done_cnt;
    request(1, 0, 3'd1, 8'h55);
    wait_done(s, "R3");
    check(status == 3'd0 && mem[1] == 8'h55, "R3 second device code accepted", status, 0);
    dev_code = 8'hB4;
  endtask

  task automatic t_prog3;
    int s;
    setup(8'hFF, 1, 3'd4, 3, 1);
    s = done_cnt;
    request(1, 0, 3'd4, 8'hA5);
    repeat (3) @(negedge clk);
    check(busy, "R9 busy during operation", busy, 1);
    wait_done(s, "R6");
    check(status == 3'd0 && mem[4] == 8'hA5, "R6 program OK", mem[4], 8'hA5);
    check(prog_pulses == 3, "R6 three attempts", prog_pulses, 3);
    check(last_width == 500, "R4 pulse width", last_width, 500);
    check(min_gap >= 300, "R5 recovery before verify", min_gap, 300);
  endtask

  task automatic t_limit(input int need, input logic [2:0] exp_st, input int exp_pulses);
    int s;
    setup(8'hFF, 1, 3'd6, need, 1);
    s = done_cnt;
    request(1, 0, 3'd6, 8'h3C);
    wait_done(s, "R6");
    check(status == exp_st, "R6 status at limit", status, exp_st);
    check(prog_pulses == exp_pulses, "R6 attempt count", prog_pulses, exp_pulses);
  endtask

  task automatic t_busy_ignore;
    int s;
    setup(8'hFF, 1, 3'd3, 2, 1);
    s = done_cnt;
    request(1, 0, 3'd3, 8'h11);
    repeat (100) @(negedge clk);
    request(1, 0, 3'd5, 8'h77);
    wait_done(s, "R10");
    repeat (20) @(negedge clk);
    check(done_cnt == s + 1, "R10 one completion only", done_cnt - s, 1);
    check(mem[5] == 8'hFF && mem[3] == 8'h11, "R10 busy request dropped", mem[5], 8'hFF);
  endtask

  task automatic t_priority;
    int s;
    setup(8'hFF, 1, '0, 1, 1);
    s = done_cnt;
    request(1, 1, 3'd2, 8'h3C);
    wait_done(s, "R10");
    check(mem[2] == 8'h3C && erase_pulses == 0 && status == 3'd0, "R10 program wins", erase_pulses, 0);
  endtask

  task automatic t_erase_ok;
    int s;
    logic ff;
    setup(8'h5A, 1, '0, 1, 3);
    s = done_cnt;
    request(0, 1, 3'd5, 8'h99);
    wait_done(s, "R8");
    check(pre_ok, "R7 all bytes 00h before erase pulse", pre_ok, 1);
    ff = 1;
    for (int i = 0; i < N; i++) if (mem[i] != 8'hFF) ff = 0;
    check(ff && status == 3'd0, "R8 erase OK", status, 0);
    check(erase_pulses == 3 && prog_pulses == N, "R8 erase pulse count", erase_pulses, 3);
  endtask

  task automatic t_erase_fail;
    int s;
    setup(8'h00, 1, '0, 1, 5);
    s = done_cnt;
    request(0, 1, 3'd0, 8'h00);
    wait_done(s, "R8");
    check(status == 3'd1 && erase_pulses == 4, "R8 erase limit", erase_pulses, 4);
  endtask

  task automatic t_reset_mid;
    setup(8'hFF, 1, 3'd7, 3, 1);
    request(1, 0, 3'd7, 8'h42);
    repeat (200) @(negedge clk);
    check(fl_prog, "R4 pulse in progress", fl_prog, 1);
    rst = 1;
    @(negedge clk);
    rst = 0;
    check(!busy && !fl_prog && !fl_erase && !done, "R11 reset aborts", {busy, fl_prog}, 0);
    check(status == 3'd0, "R11 status cleared", status, 0);
    repeat (600) @(negedge clk);
    check(!fl_prog && !busy, "R11 stays idle", busy, 0);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_novpp();
    t_lock();
    t_badid();
    t_prog3();
    t_limit(25, 3'd0, 25);
    t_limit(26, 3'd1, 25);
    t_busy_ignore();
    t_priority();
    t_erase_ok();
    t_erase_fail();
    t_reset_mid();
    finish_run();
  end

  initial begin
    repeat (180_000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 180000, 0);
    finish_run();
  end
endmodule